// File: doc/BRIEF.md
# Input Parity Sticky Error Flag

This block watches a 17-bit input word, sixteen data bits and one parity bit, for odd-parity violations. An error sets a sticky flag. The flag only changes on clock edges that a separate qualifier admits. It is cleared only by an error-clear strobe that an active-low clear-enable permits. The incoming word first passes through a one-cycle input register, so the flag reflects the word presented one edge earlier.

The flag also gates three downstream control terms. It blocks the active-low memory write strobe. Together with a test request, it forces a next-microaddress bit low. On a rising test request, it raises an active-low controller-disable term. The flag can also be read on one bit of a 16-bit readback bus when pipe readback is selected.

Top module: `inpar_guard`

## Requirements
- R1: A word is in error when the number of ones across `din` and `din_par` together is even (odd parity is expected).
- R2: With `clk_qual`=1 and `chk_en`=1, the flag after edge k+1 equals the R1 error of the word presented at edge k. The input register adds one edge of latency.
- R3: With `chk_en`=0, the flag keeps its value (0 or 1) across a qualified edge.
- R4: With `clk_qual`=0, the flag keeps its value across an edge, even when the registered word is in error.
- R5: An edge with `clr_pulse`=1 and `clr_en_n`=0 clears the flag, and this takes priority over capture. With `clr_en_n`=1, `clr_pulse` has no effect.
- R6: `wr_n` = 0 exactly when `wr_req`=1 and the flag is 0.
- R7: `nxt_n` = 0 exactly when `pre_nxt`=1, or when `tst_req`=1 and the flag is 1.
- R8: `dis_n` = 0 exactly when the flag is 1, `tst_req` is 1, and `tst_req` was 0 at the previous edge.
- R9: `rd_bus` bit 4 equals the flag when `pipe_sel`=1. All other bits are 0, and the whole bus is 0 when `pipe_sel`=0.
- R10: `rst_n`=0 asynchronously clears the flag, the registered test request, and the input register. The input register resets to an error-free word: data 0, parity 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 16 | Input data bits |
| din_par | input | 1 | Input parity bit |
| chk_en | input | 1 | Check enable for flag capture |
| clk_qual | input | 1 | Qualifier admitting flag clock edges |
| clr_pulse | input | 1 | Error-clear strobe |
| clr_en_n | input | 1 | Active-low enable for the clear strobe |
| wr_req | input | 1 | Memory write request |
| pre_nxt | input | 1 | Unconditional next-bit request |
| tst_req | input | 1 | Test-flag request |
| pipe_sel | input | 1 | Pipe readback select |
| err_flag | output | 1 | Sticky parity error flag |
| wr_n | output | 1 | Active-low write strobe |
| nxt_n | output | 1 | Active-low next-microaddress bit |
| dis_n | output | 1 | Active-low controller-disable term |
| rd_bus | output | 16 | Readback bus |

## Verification
The assertions check on every cycle that the flag holds when capture is disabled or unqualified, follows the registered error on an enabled edge, and reads 0 after a permitted clear. They also check that a set flag never lets a write strobe through. Only the bench's scenarios can show that the parity rule is odd parity over all seventeen bits and that the latency is exactly one extra edge. The scenarios also show that a clear without the enable leaves a set flag intact, and that the disable term fires only on a rising test request.

// File: rtl/inpar_pkg.sv
package inpar_pkg;
  // Error when total ones across data and parity is even.
  function automatic logic par_err(input logic [15:0] d, input logic p);
    return ~(^{d, p});
  endfunction
endpackage

// File: rtl/inpar_stage.sv
module inpar_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          din_par,
  output logic          err_det
);
  logic [DW-1:0] data_q;
  logic          par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      par_q  <= 1'b1;
    end else begin
      data_q <= din;
      par_q  <= din_par;
    end
  end

  assign err_det = ~(^{data_q, par_q});
endmodule

// File: rtl/inpar_flag.sv
module inpar_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic err_det,
  input  logic chk_en,
  input  logic clk_qual,
  input  logic clr_pulse,
  input  logic clr_en_n,
  output logic flag
);
  logic clr_hit, cap_en;
  assign clr_hit = clr_pulse & ~clr_en_n;
  assign cap_en  = clk_qual & chk_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (clr_hit) flag <= 1'b0;
    else if (cap_en)  flag <= err_det;
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !clr_hit) |=> (flag == $past(err_det)));
  a_r3_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_qual && !chk_en && !clr_hit) |=> $stable(flag));
  a_r4_hold_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_qual && !clr_hit) |=> $stable(flag));
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !flag);
endmodule

// File: rtl/inpar_gates.sv
module inpar_gates #(
  parameter int RBW    = 16,
  parameter int RB_BIT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flag,
  input  logic           wr_req,
  input  logic           pre_nxt,
  input  logic           tst_req,
  input  logic           pipe_sel,
  output logic           wr_n,
  output logic           nxt_n,
  output logic           dis_n,
  output logic [RBW-1:0] rd_bus
);
  logic tst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tst_q <= 1'b0;
    else        tst_q <= tst_req;
  end

  assign wr_n  = ~(wr_req & ~flag);
  assign nxt_n = ~(pre_nxt | (tst_req & flag));
  assign dis_n = ~(flag & tst_req & ~tst_q);

  always_comb begin
    rd_bus         = '0;
    rd_bus[RB_BIT] = pipe_sel & flag;
  end

  a_r6_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    flag |-> wr_n);
  a_r9_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_sel |-> (rd_bus == '0));
endmodule

// File: rtl/inpar_guard.sv
module inpar_guard #(
  parameter int DW     = 16,
  parameter int RBW    = 16,
  parameter int RB_BIT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  din,
  input  logic           din_par,
  input  logic           chk_en,
  input  logic           clk_qual,
  input  logic           clr_pulse,
  input  logic           clr_en_n,
  input  logic           wr_req,
  input  logic           pre_nxt,
  input  logic           tst_req,
  input  logic           pipe_sel,
  output logic           err_flag,
  output logic           wr_n,
  output logic           nxt_n,
  output logic           dis_n,
  output logic [RBW-1:0] rd_bus
);
  logic err_det;

  inpar_stage #(.DW(DW)) u_stage (
    .clk(clk), .rst_n(rst_n), .din(din), .din_par(din_par), .err_det(err_det)
  );

  inpar_flag u_flag (
    .clk(clk), .rst_n(rst_n), .err_det(err_det), .chk_en(chk_en),
    .clk_qual(clk_qual), .clr_pulse(clr_pulse), .clr_en_n(clr_en_n),
    .flag(err_flag)
  );

  inpar_gates #(.RBW(RBW), .RB_BIT(RB_BIT)) u_gates (
    .clk(clk), .rst_n(rst_n), .flag(err_flag), .wr_req(wr_req),
    .pre_nxt(pre_nxt), .tst_req(tst_req), .pipe_sel(pipe_sel),
    .wr_n(wr_n), .nxt_n(nxt_n), .dis_n(dis_n), .rd_bus(rd_bus)
  );
endmodule

// File: tb/sim_inpar_guard.sv
module sim_inpar_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] din = '0;
  logic din_par = 1'b1, chk_en = 1'b0, clk_qual = 1'b0, clr_pulse = 1'b0, clr_en_n = 1'b1;
  logic wr_req = 1'b0, pre_nxt = 1'b0, tst_req = 1'b0, pipe_sel = 1'b0;
  logic err_flag, wr_n, nxt_n, dis_n;
  logic [15:0] rd_bus;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  inpar_guard u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_err(input logic [15:0] d, input logic p);
    int ones = p;
    for (int i = 0; i < 16; i++) ones += d[i];
    return (ones % 2) == 0;
  endfunction

  task automatic edge1();
    @(negedge clk);
  endtask

  task automatic load(input logic [15:0] d, input logic p);
    din = d; din_par = p; chk_en = 1'b1; clk_qual = 1'b1;
    edge1(); edge1();
  endtask

  task automatic t_reset();
    chk("R10 flag", {15'b0, err_flag}, 16'd0);
    pipe_sel = 1'b1; #1;
    chk("R10 bus", rd_bus, 16'd0);
    pipe_sel = 1'b0;
  endtask

  task automatic t_capture();
    logic [15:0] pats [6] = '{16'h0000, 16'h0001, 16'hffff, 16'h8000, 16'h1234, 16'h0003};
    for (int i = 0; i < 6; i++) begin
      for (int p = 0; p < 2; p++) begin
        load(pats[i], p[0]);
        chk("R1 R2 parity", {15'b0, err_flag}, {15'b0, exp_err(pats[i], p[0])});
      end
    end
    // latency: error word presented, after one edge flag not yet set
    load(16'h0000, 1'b1);
    din = 16'h0000; din_par = 1'b0; edge1();
    chk("R2 latency one", {15'b0, err_flag}, 16'd0);
    edge1();
    chk("R2 latency two", {15'b0, err_flag}, 16'd1);
  endtask

  task automatic t_hold();
    load(16'h0000, 1'b0);
    chk_en = 1'b0; din_par = 1'b1; edge1(); edge1();
    chk("R3 hold one", {15'b0, err_flag}, 16'd1);
    clr_pulse = 1'b1; clr_en_n = 1'b0; edge1(); clr_pulse = 1'b0; clr_en_n = 1'b1;
    din_par = 1'b0; edge1(); edge1();
    chk("R3 hold zero", {15'b0, err_flag}, 16'd0);
    chk_en = 1'b1; clk_qual = 1'b0; edge1(); edge1();
    chk("R4 no qual", {15'b0, err_flag}, 16'd0);
    clk_qual = 1'b1; edge1();
    chk("R4 qual back", {15'b0, err_flag}, 16'd1);
  endtask

  task automatic t_clear();
    load(16'h0000, 1'b0);
    chk_en = 1'b0;
    clr_pulse = 1'b1; clr_en_n = 1'b1; edge1();
    chk("R5 clear blocked", {15'b0, err_flag}, 16'd1);
    chk_en = 1'b1; clr_en_n = 1'b0; edge1();
    chk("R5 clear priority", {15'b0, err_flag}, 16'd0);
    clr_pulse = 1'b0; clr_en_n = 1'b1;
  endtask

  task automatic t_gates();
    load(16'h0000, 1'b1);
    chk_en = 1'b0;
    wr_req = 1'b1; #1;
    chk("R6 write ok", {15'b0, wr_n}, 16'd0);
    load(16'h0000, 1'b0); chk_en = 1'b0;
    #1 chk("R6 write blocked", {15'b0, wr_n}, 16'd1);
    wr_req = 1'b0;
    tst_req = 1'b1; #1;
    chk("R7 test and flag", {15'b0, nxt_n}, 16'd0);
    tst_req = 1'b0; #1;
    chk("R7 idle", {15'b0, nxt_n}, 16'd1);
    pre_nxt = 1'b1; #1;
    chk("R7 pre", {15'b0, nxt_n}, 16'd0);
    pre_nxt = 1'b0;
    edge1();
    tst_req = 1'b1; #1;
    chk("R8 rising", {15'b0, dis_n}, 16'd0);
    edge1();
    chk("R8 held", {15'b0, dis_n}, 16'd1);
    tst_req = 1'b0;
    pipe_sel = 1'b1; #1;
    chk("R9 readback set", rd_bus, 16'h0010);
    pipe_sel = 1'b0; #1;
    chk("R9 deselected", rd_bus, 16'h0000);
  endtask

  initial begin
    #1 t_reset();
    edge1(); rst_n = 1'b1; edge1();
    chk("R10 after release", {15'b0, err_flag}, 16'd0);
    t_capture();
    t_hold();
    t_clear();
    t_gates();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule